// File: doc/BRIEF.md
# Stack and Branch Control Sequencer

This unit owns a processor's 16-bit program counter and stack pointer and changes them on command. A single-cycle `start` presents one of nine commands: absolute jump, relative jump, call, restart, return, return-from-interrupt, push, pop and a byte store into the top 256-byte page of the address space. Any command may be gated by a flag condition taken from the zero and carry flags. Jumps finish in the cycle of acceptance. Stack words and the page store use a byte-wide memory port, one byte per cycle.

The stack grows downward. A word sits in memory low byte first, at the lower address. A push or call writes the high byte at SP−1 and then the low byte at SP−2. A pop or return reads the low byte at SP and then the high byte at SP+1. The memory answers reads combinationally in the cycle `mem_re` is high. The surrounding core waits for `done` before it issues the next command.

Top module: `stack_branch_seq`

## Requirements
- R1: After reset PC is 0x0000, SP is 0xFFFE, and `busy`, `done`, `ime_set`, `mem_we` and `mem_re` are low.
- R2: Command code 0 (absolute jump) loads `target` into PC. `done` is high in the cycle after acceptance and `busy` never rises.
- R3: Command code 1 (relative jump) adds `target[7:0]`, sign-extended, to PC modulo 65536. It completes like R2.
- R4: With `cond_en` high a command acts only if its condition holds: `cond_sel` 00 means Z clear, 01 Z set, 10 C clear, 11 C set. A failed command leaves PC and SP unchanged, makes no memory access, never raises `busy`, and still pulses `done` in the next cycle.
- R5: Command code 2 (call) writes PC+3 high byte at SP−1, then low byte at SP−2, on consecutive cycles. SP then drops by 2 and PC takes `target`.
- R6: Command code 3 (restart) stores PC+1 in the same way as R5. PC then becomes `target[2:0]` × 8.
- R7: Command code 6 (push) stores `wdata` in the same way as R5, lowers SP by 2 and leaves PC unchanged.
- R8: Command code 7 (pop) reads the low byte at SP and then the high byte at SP+1. It returns the word on `pop_data`, raises SP by 2 and leaves PC unchanged.
- R9: Command codes 4 (return) and 5 (return-from-interrupt) load PC from the word read as in R8 and raise SP by 2. Only code 5 pulses `ime_set`, in the same cycle as `done`.
- R10: A stack-word command holds `busy` high for exactly two cycles, one byte access each, never reading and writing at once. `done` pulses in the following cycle with `busy` low.
- R11: Command code 8 (page store) writes `wdata[7:0]` to 0xFF00 + `target[7:0]` in one busy cycle and leaves PC and SP unchanged. Codes 9 to 15 complete like a failed condition.
- R12: A `start` seen while `busy` is high is ignored, and PC and SP hold while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| cmd | input | 4 | Command code |
| cond_en | input | 1 | Gate the command with a flag condition |
| cond_sel | input | 2 | Flag condition code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| target | input | 16 | Jump or call address, relative offset, restart index or page offset |
| wdata | input | 16 | Push word or page-store byte |
| mem_rdata | input | 8 | Read byte from memory |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| pop_data | output | 16 | Last popped word |
| ime_set | output | 1 | Interrupt-enable set pulse |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Command finished pulse |

## Verification
A wrong sequencer state shows up as a byte at the wrong address or in the wrong order. It is seen on the memory port within the two busy cycles of that command. A bad PC or SP update is visible on `pc_o` or `sp_o` in the `done` cycle. A stale return address or saved low byte shows up one command later, when the matching pop or return brings back a word that differs from the one pushed. A leaked or missing `ime_set` pulse is seen in the same cycle as `done`.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_JP     = 4'd0,
        OP_JR     = 4'd1,
        OP_CALL   = 4'd2,
        OP_RST    = 4'd3,
        OP_RET    = 4'd4,
        OP_RETI   = 4'd5,
        OP_PUSH   = 4'd6,
        OP_POP    = 4'd7,
        OP_HSTORE = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC1 = 2'd1,
        ST_ACC2 = 2'd2
    } st_e;

    typedef struct packed {
        st_e                st;
        op_e                op;
        logic [WORD_W-1:0]  pc;
        logic [WORD_W-1:0]  sp;
        logic [WORD_W-1:0]  word;
        logic [WORD_W-1:0]  aux;
        logic [WORD_W-1:0]  pop;
        logic [BYTE_W-1:0]  lo;
        logic               done;
        logic               ime;
    } regs_t;

    function automatic logic op_reads(op_e op);
        return (op == OP_RET) || (op == OP_RETI) || (op == OP_POP);
    endfunction
endpackage

// File: rtl/sbs_cond.sv
module sbs_cond (
    input  logic       en,
    input  logic [1:0] sel,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       pass
);
    logic flag;
    always_comb begin
        flag = sel[1] ? flag_c : flag_z;
        pass = !en || (flag == sel[0]);
    end
endmodule

// File: rtl/sbs_port.sv
module sbs_port
    import sbs_pkg::*;
(
    input  st_e               st,
    input  op_e               op,
    input  logic [WORD_W-1:0] sp,
    input  logic [WORD_W-1:0] aux,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] addr,
    output logic              we,
    output logic              re,
    output logic [BYTE_W-1:0] wdata
);
    always_comb begin
        addr  = '0;
        we    = 1'b0;
        re    = 1'b0;
        wdata = '0;
        if (st != ST_IDLE) begin
            if (op == OP_HSTORE) begin
                addr  = aux;
                we    = 1'b1;
                wdata = word[BYTE_W-1:0];
            end else if (op_reads(op)) begin
                re   = 1'b1;
                addr = (st == ST_ACC1) ? sp : sp + WORD_W'(1);
            end else begin
                we = 1'b1;
                if (st == ST_ACC1) begin
                    addr  = sp - WORD_W'(1);
                    wdata = word[WORD_W-1:BYTE_W];
                end else begin
                    addr  = sp - WORD_W'(2);
                    wdata = word[BYTE_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/stack_branch_seq.sv
module stack_branch_seq
    import sbs_pkg::*;
#(
    parameter logic [15:0] PC_RESET   = 16'h0000,
    parameter logic [15:0] SP_RESET   = 16'hFFFE,
    parameter logic [15:0] HIGH_PAGE  = 16'hFF00,
    parameter int          VEC_SHIFT  = 3,
    parameter int          VEC_BITS   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  cmd,
    input  logic        cond_en,
    input  logic [1:0]  cond_sel,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic [15:0] target,
    input  logic [15:0] wdata,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    output logic [15:0] pc_o,
    output logic [15:0] sp_o,
    output logic [15:0] pop_data,
    output logic        ime_set,
    output logic        busy,
    output logic        done
);
    localparam int CALL_LEN = 3;
    localparam int RST_LEN  = 1;

    regs_t q, d;
    logic  pass;
    op_e   op_in;

    assign op_in = op_e'(cmd);

    sbs_cond u_cond (
        .en     (cond_en),
        .sel    (cond_sel),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .pass   (pass)
    );

    sbs_port u_port (
        .st    (q.st),
        .op    (q.op),
        .sp    (q.sp),
        .aux   (q.aux),
        .word  (q.word),
        .addr  (mem_addr),
        .we    (mem_we),
        .re    (mem_re),
        .wdata (mem_wdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ime  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op = op_in;
                    if (!pass) begin
                        d.done = 1'b1;
                    end else begin
                        case (op_in)
                            OP_JP: begin
                                d.pc   = target;
                                d.done = 1'b1;
                            end
                            OP_JR: begin
                                d.pc   = q.pc + {{(WORD_W-BYTE_W){target[BYTE_W-1]}},
                                                 target[BYTE_W-1:0]};
                                d.done = 1'b1;
                            end
                            OP_CALL: begin
                                d.word = q.pc + WORD_W'(CALL_LEN);
                                d.aux  = target;
                                d.st   = ST_ACC1;
                            end
                            OP_RST: begin
                                d.word = q.pc + WORD_W'(RST_LEN);
                                d.aux  = WORD_W'({target[VEC_BITS-1:0], {VEC_SHIFT{1'b0}}});
                                d.st   = ST_ACC1;
                            end
                            OP_PUSH: begin
                                d.word = wdata;
                                d.st   = ST_ACC1;
                            end
                            OP_RET, OP_RETI, OP_POP: begin
                                d.st = ST_ACC1;
                            end
                            OP_HSTORE: begin
                                d.aux  = HIGH_PAGE | {{(WORD_W-BYTE_W){1'b0}}, target[BYTE_W-1:0]};
                                d.word = wdata;
                                d.st   = ST_ACC2;
                            end
                            default: d.done = 1'b1;
                        endcase
                    end
                end
            end
            ST_ACC1: begin
                if (op_reads(q.op)) d.lo = mem_rdata;
                d.st = ST_ACC2;
            end
            ST_ACC2: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                case (q.op)
                    OP_CALL, OP_RST: begin
                        d.sp = q.sp - WORD_W'(2);
                        d.pc = q.aux;
                    end
                    OP_PUSH: d.sp = q.sp - WORD_W'(2);
                    OP_RET, OP_RETI: begin
                        d.pc  = {mem_rdata, q.lo};
                        d.sp  = q.sp + WORD_W'(2);
                        d.ime = (q.op == OP_RETI);
                    end
                    OP_POP: begin
                        d.pop = {mem_rdata, q.lo};
                        d.sp  = q.sp + WORD_W'(2);
                    end
                    default: ;
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.op   <= OP_JP;
            q.pc   <= PC_RESET;
            q.sp   <= SP_RESET;
        end else begin
            q <= d;
        end
    end

    assign pc_o     = q.pc;
    assign sp_o     = q.sp;
    assign pop_data = q.pop;
    assign ime_set  = q.ime;
    assign done     = q.done;
    assign busy     = (q.st != ST_IDLE);
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        ime_set,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] pc_o,
    input logic [15:0] sp_o
);
    assert_ime_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ime_set |-> done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fall_then_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_no_rw_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_access_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    assert_hold_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(pc_o) && $stable(sp_o)));
endmodule

bind stack_branch_seq sbs_checker u_sbs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .ime_set (ime_set),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .pc_o    (pc_o),
    .sp_o    (sp_o)
);

// File: tb/stack_branch_seq_test.sv
`timescale 1ns/1ps
module stack_branch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic        cond_en = 1'b0;
    logic [1:0]  cond_sel = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] target = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [15:0] pc_o, sp_o, pop_data;
    logic        ime_set, busy, done;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [0:255];
    logic [15:0] wa [0:3];
    logic [7:0]  wd [0:3];
    int          wn = 0;
    int          rn = 0;
    logic [15:0] ra [0:3];
    int          busy_cyc;
    logic        ime_seen;

    always #4 clk = ~clk;

    stack_branch_seq uut (.*);

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (wn < 4) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
            wn <= wn + 1;
        end
        if (mem_re) begin
            if (rn < 4) ra[rn] <= mem_addr;
            rn <= rn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [15:0] t, input logic [15:0] w,
                       input logic ce, input logic [1:0] cs);
        @(negedge clk);
        wn = 0; rn = 0; busy_cyc = 0; ime_seen = 1'b0;
        cmd = c; target = t; wdata = w; cond_en = ce; cond_sel = cs; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cond_en = 1'b0;
        for (int i = 0; i < 10 && !done; i++) begin
            if (busy) busy_cyc++;
            @(negedge clk);
        end
        if (!done) chk("R10 done timeout", 0, 1);
        ime_seen = ime_set;
    endtask

    task automatic t_reset;
        chk("R1 pc", pc_o, 16'h0000);
        chk("R1 sp", sp_o, 16'hFFFE);
        chk("R1 strobes", {busy, done, ime_set, mem_we, mem_re}, 0);
    endtask

    task automatic t_jumps;
        run(4'd0, 16'h1234, 0, 0, 0);
        chk("R2 jp pc", pc_o, 16'h1234);
        chk("R2 no busy", busy_cyc, 0);
        run(4'd1, 16'h0010, 0, 0, 0);
        chk("R3 jr fwd", pc_o, 16'h1244);
        run(4'd1, 16'h00FE, 0, 0, 0);
        chk("R3 jr back", pc_o, 16'h1242);
        run(4'd0, 16'hFFF0, 0, 0, 0);
        run(4'd1, 16'h0020, 0, 0, 0);
        chk("R3 jr wrap", pc_o, 16'h0010);
    endtask

    task automatic t_cond;
        flag_z = 1'b0; flag_c = 1'b1;
        run(4'd0, 16'h5555, 0, 1, 2'b01);
        chk("R4 z set false", pc_o, 16'h0010);
        run(4'd0, 16'h5555, 0, 1, 2'b10);
        chk("R4 c clear false", pc_o, 16'h0010);
        run(4'd2, 16'h5555, 0, 1, 2'b10);
        chk("R4 call false pc", pc_o, 16'h0010);
        chk("R4 call false sp", sp_o, 16'hFFFE);
        chk("R4 call false no access", {wn[3:0], busy_cyc[3:0]}, 0);
        run(4'd1, 16'h0000, 0, 1, 2'b00);
        chk("R4 z clear true", pc_o, 16'h0010);
        run(4'd0, 16'h0010, 0, 1, 2'b11);
        chk("R4 c set true", pc_o, 16'h0010);
    endtask

    task automatic t_call;
        run(4'd2, 16'h2000, 0, 0, 0);
        chk("R5 wr0", {wa[0], wd[0]}, {16'hFFFD, 8'h00});
        chk("R5 wr1", {wa[1], wd[1]}, {16'hFFFC, 8'h13});
        chk("R5 sp", sp_o, 16'hFFFC);
        chk("R5 pc", pc_o, 16'h2000);
        chk("R10 call busy", busy_cyc, 2);
    endtask

    task automatic t_push_pop;
        run(4'd6, 0, 16'hBEEF, 0, 0);
        chk("R7 wr0", {wa[0], wd[0]}, {16'hFFFB, 8'hBE});
        chk("R7 wr1", {wa[1], wd[1]}, {16'hFFFA, 8'hEF});
        chk("R7 sp pc", {sp_o, pc_o}, {16'hFFFA, 16'h2000});
        run(4'd7, 0, 0, 0, 0);
        chk("R8 pop data", pop_data, 16'hBEEF);
        chk("R8 read order", {ra[0], ra[1]}, {16'hFFFA, 16'hFFFB});
        chk("R8 sp pc", {sp_o, pc_o}, {16'hFFFC, 16'h2000});
        chk("R10 pop busy", busy_cyc, 2);
    endtask

    task automatic t_rst_ret;
        run(4'd3, 16'h0005, 0, 0, 0);
        chk("R6 wr", {wa[0], wd[0], wa[1], wd[1]}, {16'hFFFB, 8'h20, 16'hFFFA, 8'h01});
        chk("R6 pc sp", {pc_o, sp_o}, {16'h0028, 16'hFFFA});
        run(4'd5, 0, 0, 0, 0);
        chk("R9 reti pc sp", {pc_o, sp_o}, {16'h2001, 16'hFFFC});
        chk("R9 reti ime", ime_seen, 1);
        @(negedge clk);
        chk("R9 ime one cycle", ime_set, 0);
        flag_z = 1'b1;
        run(4'd4, 0, 0, 1, 2'b00);
        chk("R4 ret false", {pc_o, sp_o, rn[3:0]}, {16'h2001, 16'hFFFC, 4'd0});
        run(4'd4, 0, 0, 1, 2'b01);
        chk("R9 ret pc sp", {pc_o, sp_o}, {16'h0013, 16'hFFFE});
        chk("R9 ret no ime", ime_seen, 0);
    endtask

    task automatic t_hstore;
        run(4'd8, 16'h0042, 16'h005A, 0, 0);
        chk("R11 store", {wn[3:0], wa[0], wd[0]}, {4'd1, 16'hFF42, 8'h5A});
        chk("R11 busy one", busy_cyc, 1);
        chk("R11 regs", {pc_o, sp_o}, {16'h0013, 16'hFFFE});
        run(4'd12, 16'h4444, 0, 0, 0);
        chk("R11 undefined code", {pc_o, sp_o, wn[3:0]}, {16'h0013, 16'hFFFE, 4'd0});
    endtask

    task automatic t_start_busy;
        @(negedge clk);
        cmd = 4'd6; wdata = 16'hA1B2; start = 1'b1;
        @(negedge clk);
        cmd = 4'd0; target = 16'h7777;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R12 done after push", done, 1);
        @(negedge clk);
        @(negedge clk);
        chk("R12 pc ignored", pc_o, 16'h0013);
        chk("R12 sp", sp_o, 16'hFFFC);
        run(4'd7, 0, 0, 0, 0);
        chk("R12 pushed word", pop_data, 16'hA1B2);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_jumps;
        t_cond;
        t_call;
        t_push_pop;
        t_rst_ret;
        t_hstore;
        t_start_busy;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule